// File: doc/BRIEF.md
# Redistributor Region Map Table

This block keeps a small, ordered table of redistributor regions and translates a redistributor number into the physical base address of that redistributor's frames. Software configures it by presenting 64-bit region descriptors on a write strobe. Each descriptor names a slot index, a region base address and the number of redistributors packed into the region. The block validates every descriptor and reports a 3-bit result code in the same cycle as the strobe. A rejected descriptor changes nothing.

A read strobe with an index returns the stored descriptor, or a not-found code for an index that has not been registered. A combinational lookup port takes a redistributor number and walks the registered regions in index order. Region 0 holds the lowest numbers, region 1 the next ones, and so on. Each redistributor takes two consecutive 64 KB frames (128 KB). The port returns the frame base together with a valid flag. A status output shows whether the registered regions together cover the configured number of CPUs.

Top module: `rdmap_top`

## Requirements
- R1: Descriptor fields are count in bits 63:52, base address bits 51:16 in bits 51:16, flags in bits 15:12 and index in bits 11:0. A write is accepted only if all of these hold: the index equals the number of regions already registered, the table has a free slot, the count is nonzero, the flags are zero and the region fits. An accepted write returns code 0 and stores the region.
- R2: A write whose index is greater than the number of regions already registered returns code 1 (invalid).
- R3: A write with a count of zero, or with nonzero flags, returns code 1 (invalid).
- R4: A write to an index that is already registered returns code 2 (already exists).
- R5: When all DEPTH slots are filled, a write with index DEPTH returns code 1 (invalid).
- R6: A write whose region end (base + count × 128 KB) lies beyond 2^PA_W returns code 4 (out of range). A region that ends exactly at 2^PA_W is accepted.
- R7: When several checks fail at once, the code follows this priority: already-exists first, then invalid index or full table, then invalid count or flags, then out of range.
- R8: A rejected write leaves the table unchanged. Read-back and lookup behave afterwards exactly as before the write.
- R9: A read of a registered index returns code 0 and the descriptor {count, base, 4'b0, index}. A read of an unregistered index returns code 3 (not found) and zero data.
- R10: Let n be a lookup number below the total count of all registered regions, let k be the region that holds n, and let s be the first number in region k. The lookup returns valid = 1 and the address base_k + (n − s) × 128 KB, in the same cycle. For n at or beyond the total, it returns valid = 0 and address 0.
- R11: The CPU-coverage output is 1 exactly when the total count of the registered regions is at least NUM_CPUS.
- R12: With no strobe asserted, both result codes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; empties the table |
| wrEn | input | 1 | Descriptor write strobe |
| wrDesc | input | 64 | Region descriptor to write |
| wrErr | output | 3 | Write result code, same cycle as wrEn |
| rdEn | input | 1 | Read-back strobe |
| rdIdx | input | 12 | Index to read back |
| rdDesc | output | 64 | Stored descriptor, or zero |
| rdErr | output | 3 | Read result code, same cycle as rdEn |
| lkNum | input | SUM_W | Redistributor number to resolve |
| lkAddr | output | PA_W | Frame base address of that redistributor |
| lkValid | output | 1 | lkNum falls inside a registered region |
| cpusCovered | output | 1 | Registered count covers NUM_CPUS |

## Verification
The bench sweeps every lookup number from zero to a little past the total. It compares each result with addresses computed from its own model of the regions, so an off-by-one in a region's starting number, or a frame stride of 64 KB instead of 128 KB, would misplace every redistributor after region 0. It probes the range limit on both sides, with one region that ends exactly at 2^PA_W and one that ends a single frame pair beyond. A strict greater-or-equal compare there would wrongly refuse the first of these. It re-registers an index with bad flags, where a check order that puts flags first would report invalid instead of already-exists. After every rejected write it reads back and looks up again, which shows any design that stores part of a refused descriptor or advances its region counter.

// File: rtl/rdmap_pkg.sv
package rdmap_pkg;

  localparam int IDX_W  = 12;
  localparam int CNT_W  = 12;
  localparam int BASE_W = 36;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_INVALID  = 3'd1,
    ERR_EXISTS   = 3'd2,
    ERR_NOTFOUND = 3'd3,
    ERR_RANGE    = 3'd4
  } errCode_t;

  typedef struct packed {
    logic             store;
    logic [IDX_W-1:0] slot;
  } tblCmd_t;

endpackage

// File: rtl/rdmap_ctrl.sv
module rdmap_ctrl
  import rdmap_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PA_W  = 48,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [63:0]   wrDesc,
  output logic [2:0]    wrErr,
  output tblCmd_t       cmd,
  output logic [CW-1:0] numRegs
);

  logic [IDX_W-1:0]  idxF;
  logic [3:0]        flagsF;
  logic [BASE_W-1:0] baseF;
  logic [CNT_W-1:0]  cntF;
  logic [63:0]       regionEnd;
  logic [63:0]       paLimit;
  errCode_t          verdict;

  assign cntF   = wrDesc[63:52];
  assign baseF  = wrDesc[51:16];
  assign flagsF = wrDesc[15:12];
  assign idxF   = wrDesc[11:0];

  assign regionEnd = {12'd0, baseF, 16'd0} + ({52'd0, cntF} << 17);
  assign paLimit   = 64'd1 << PA_W;

  always_comb begin
    verdict = ERR_NONE;
    if (idxF < IDX_W'(numRegs))
      verdict = ERR_EXISTS;
    else if (idxF != IDX_W'(numRegs) || numRegs == CW'(DEPTH))
      verdict = ERR_INVALID;
    else if (flagsF != 4'd0 || cntF == '0)
      verdict = ERR_INVALID;
    else if (regionEnd > paLimit)
      verdict = ERR_RANGE;
  end

  assign wrErr     = wrEn ? verdict : ERR_NONE;
  assign cmd.store = wrEn && (verdict == ERR_NONE);
  assign cmd.slot  = idxF;

  always_ff @(posedge clk) begin
    if (!rstN)          numRegs <= '0;
    else if (cmd.store) numRegs <= numRegs + 1'b1;
  end

  // R8
  reject_keeps_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrErr != ERR_NONE) |=> $stable(numRegs));

  // R1
  accept_grows_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrErr == ERR_NONE) |=> numRegs == $past(numRegs) + 1'b1);

  // R5
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rstN)
    numRegs <= CW'(DEPTH));

  // R12
  idle_write_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> wrErr == ERR_NONE);

endmodule

// File: rtl/rdmap_table.sv
module rdmap_table
  import rdmap_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int PA_W     = 48,
  parameter int NUM_CPUS = 4,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int SUM_W   = CNT_W + $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tblCmd_t           cmd,
  input  logic [BASE_W-1:0] wrBase,
  input  logic [CNT_W-1:0]  wrCnt,
  input  logic [CW-1:0]     numRegs,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [63:0]       rdDesc,
  output logic [2:0]        rdErr,
  input  logic [SUM_W-1:0]  lkNum,
  output logic [PA_W-1:0]   lkAddr,
  output logic              lkValid,
  output logic              cpusCovered
);

  logic [BASE_W-1:0] baseQ    [DEPTH];
  logic [CNT_W-1:0]  cntQ     [DEPTH];
  logic [SUM_W-1:0]  startSum [DEPTH+1];

  assign startSum[0] = '0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[i] <= '0;
        cntQ[i]  <= '0;
      end else if (cmd.store && cmd.slot == IDX_W'(i)) begin
        baseQ[i] <= wrBase;
        cntQ[i]  <= wrCnt;
      end
    end
    assign startSum[i+1] = startSum[i] +
      ((CW'(i) < numRegs) ? SUM_W'(cntQ[i]) : SUM_W'(0));
  end

  assign cpusCovered = startSum[DEPTH] >= SUM_W'(NUM_CPUS);

  logic rdHit;
  assign rdHit = rdIdx < IDX_W'(numRegs);

  always_comb begin
    rdDesc = '0;
    rdErr  = ERR_NONE;
    if (rdEn) begin
      if (!rdHit) rdErr = ERR_NOTFOUND;
      else begin
        for (int i = 0; i < DEPTH; i++)
          if (rdIdx == IDX_W'(i)) rdDesc = {cntQ[i], baseQ[i], 4'd0, rdIdx};
      end
    end
  end

  always_comb begin
    lkValid = 1'b0;
    lkAddr  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < numRegs && lkNum >= startSum[i] && lkNum < startSum[i+1]) begin
        lkValid = 1'b1;
        lkAddr  = PA_W'({baseQ[i], 16'd0}) + (PA_W'(lkNum - startSum[i]) << 17);
      end
    end
  end

  // R10
  lookup_frame_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> lkAddr[15:0] == 16'd0);

  // R10
  lookup_miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> lkAddr == '0);

  // R9
  notfound_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdErr == ERR_NOTFOUND) |-> rdDesc == 64'd0);

  // R12
  idle_read_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdErr == ERR_NONE);

endmodule

// File: rtl/rdmap_top.sv
module rdmap_top
  import rdmap_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int PA_W     = 48,
  parameter int NUM_CPUS = 4,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int SUM_W   = CNT_W + $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [63:0]      wrDesc,
  output logic [2:0]       wrErr,
  input  logic             rdEn,
  input  logic [11:0]      rdIdx,
  output logic [63:0]      rdDesc,
  output logic [2:0]       rdErr,
  input  logic [SUM_W-1:0] lkNum,
  output logic [PA_W-1:0]  lkAddr,
  output logic             lkValid,
  output logic             cpusCovered
);

  tblCmd_t       cmd;
  logic [CW-1:0] numRegs;

  rdmap_ctrl #(.DEPTH(DEPTH), .PA_W(PA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrDesc(wrDesc),
    .wrErr(wrErr), .cmd(cmd), .numRegs(numRegs)
  );

  rdmap_table #(.DEPTH(DEPTH), .PA_W(PA_W), .NUM_CPUS(NUM_CPUS)) u_table (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .wrBase(wrDesc[51:16]), .wrCnt(wrDesc[63:52]), .numRegs(numRegs),
    .rdEn(rdEn), .rdIdx(rdIdx), .rdDesc(rdDesc), .rdErr(rdErr),
    .lkNum(lkNum), .lkAddr(lkAddr), .lkValid(lkValid),
    .cpusCovered(cpusCovered)
  );

endmodule

// File: tb/rdmap_top_test.sv
module rdmap_top_test;

  localparam int DEPTH = 4;
  localparam int PA_W  = 32;
  localparam int NCPU  = 6;
  localparam int SUM_W = 12 + $clog2(DEPTH) + 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [63:0]      wrDesc = '0;
  logic [2:0]       wrErr;
  logic             rdEn = 1'b0;
  logic [11:0]      rdIdx = '0;
  logic [63:0]      rdDesc;
  logic [2:0]       rdErr;
  logic [SUM_W-1:0] lkNum = '0;
  logic [PA_W-1:0]  lkAddr;
  logic             lkValid;
  logic             cpusCovered;

  rdmap_top #(.DEPTH(DEPTH), .PA_W(PA_W), .NUM_CPUS(NCPU)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrDesc(wrDesc), .wrErr(wrErr),
    .rdEn(rdEn), .rdIdx(rdIdx), .rdDesc(rdDesc), .rdErr(rdErr),
    .lkNum(lkNum), .lkAddr(lkAddr), .lkValid(lkValid),
    .cpusCovered(cpusCovered)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [35:0] mBase [DEPTH];
  logic [11:0] mCnt  [DEPTH];
  int          mNum  = 0;

  function automatic logic [63:0] mk(input logic [11:0] c, input logic [35:0] b,
                                     input logic [3:0] f, input logic [11:0] i);
    return {c, b, f, i};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input string req, input logic [63:0] d, input logic [2:0] expErr);
    @(negedge clk);
    wrEn = 1'b1; wrDesc = d;
    #1 chk(req, 64'(wrErr), 64'(expErr));
    @(negedge clk);
    wrEn = 1'b0;
    if (expErr == 3'd0) begin
      mBase[mNum] = d[51:16];
      mCnt[mNum]  = d[63:52];
      mNum++;
    end
  endtask

  task automatic doRead(input string req, input int idx);
    logic [63:0] expD;
    logic [2:0]  expE;
    @(negedge clk);
    rdEn = 1'b1; rdIdx = 12'(idx);
    if (idx < mNum) begin
      expD = mk(mCnt[idx], mBase[idx], 4'd0, 12'(idx)); expE = 3'd0;
    end else begin
      expD = '0; expE = 3'd3;
    end
    #1;
    chk(req, 64'(rdErr), 64'(expE));
    chk(req, rdDesc, expD);
    rdEn = 1'b0;
  endtask

  task automatic doLook(input string req, input int n);
    int          start = 0;
    logic        expV  = 1'b0;
    logic [63:0] expA  = '0;
    for (int k = 0; k < mNum; k++) begin
      if (n >= start && n < start + int'(mCnt[k])) begin
        expV = 1'b1;
        expA = {12'd0, mBase[k], 16'd0} + 64'((n - start) * 131072);
      end
      start += int'(mCnt[k]);
    end
    @(negedge clk);
    lkNum = SUM_W'(n);
    #1;
    chk(req, 64'(lkValid), 64'(expV));
    chk(req, 64'(lkAddr), expA);
  endtask

  initial begin
    #500us;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // Reset state (R9, R10, R11, R12)
    #1;
    chk("R12 idle wrErr", 64'(wrErr), 0);
    chk("R12 idle rdErr", 64'(rdErr), 0);
    chk("R11 reset coverage", 64'(cpusCovered), 0);
    doRead("R9 reset read", 0);
    doLook("R10 reset lookup", 0);

    // Rejections on an empty table
    doWrite("R2 skip index", mk(12'd1, 36'h1, 4'd0, 12'd1), 3'd1);
    doWrite("R3 zero count", mk(12'd0, 36'h1, 4'd0, 12'd0), 3'd1);
    doWrite("R3 flags set", mk(12'd1, 36'h1, 4'd5, 12'd0), 3'd1);
    doWrite("R6 base beyond range", mk(12'd1, 36'h10000, 4'd0, 12'd0), 3'd4);
    doRead("R8 read after rejects", 0);
    doLook("R8 lookup after rejects", 0);

    // First region
    doWrite("R1 accept region 0", mk(12'd2, 36'h1, 4'd0, 12'd0), 3'd0);
    doRead("R1 R9 read region 0", 0);
    doWrite("R4 R7 reuse with bad flags", mk(12'd1, 36'h5, 4'd3, 12'd0), 3'd2);
    doRead("R8 region 0 unchanged", 0);

    // Range boundary for region 1
    doWrite("R6 one pair beyond limit", mk(12'd4, 36'hFFFA, 4'd0, 12'd1), 3'd4);
    doLook("R8 no region 1 yet", 2);
    doWrite("R6 ends exactly at limit", mk(12'd3, 36'hFFFA, 4'd0, 12'd1), 3'd0);
    #1 chk("R11 total 5 below 6", 64'(cpusCovered), 0);

    doWrite("R2 skip to 3", mk(12'd1, 36'h300, 4'd0, 12'd3), 3'd1);
    doWrite("R1 accept region 2", mk(12'd1, 36'h100, 4'd0, 12'd2), 3'd0);
    #1 chk("R11 total 6 covers", 64'(cpusCovered), 1);
    doWrite("R1 accept region 3", mk(12'd2, 36'h200, 4'd0, 12'd3), 3'd0);
    doWrite("R5 table full", mk(12'd1, 36'h400, 4'd0, 12'd4), 3'd1);

    for (int i = 0; i < DEPTH + 3; i++) doRead("R9 read sweep", i);
    for (int n = 0; n < 12; n++) doLook("R10 lookup sweep", n);

    @(negedge clk);
    #1;
    chk("R12 idle wrErr end", 64'(wrErr), 0);
    chk("R12 idle rdErr end", 64'(rdErr), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule